// File: doc/BRIEF.md
# Division-Free Transform Coefficient Quantizer

This block quantizes one signed transform coefficient per clock into a signed 16-bit level. The quantization parameter and a transform size code come in alongside each coefficient. The scaling factor depends on the parameter's remainder modulo six. The right-shift count is built from the parameter's quotient by six together with the block size. An integer rounding term, already shifted into place, is added to the scaled magnitude before the shift. The sign of the input is applied again at the end.

A small comparison chain splits the parameter into its quotient and remainder, so the block needs no divider. The rounding term is an integer, so there is no fractional arithmetic. The datapath has two register stages. A result leaves the block two clocks after its coefficient enters, and a new coefficient may be accepted on every clock. The coefficient width is a parameter and defaults to 20 bits, which makes saturation of the 16-bit result reachable.

Top module: `coef_quantizer`

## Requirements
- R1: `out_valid` is high exactly two rising clock edges after a cycle in which `in_valid` was high, so one coefficient can be accepted on every cycle, back to back.
- R2: The scaling factor is picked by qp mod 6. For remainders 0, 1, 2, 3, 4 and 5 the factors are 26214, 23302, 20560, 16384, 14564 and 13107.
- R3: The shift count is qbits = 19 + floor(qp/6) − size_code. The size_code values 0, 1, 2 and 3 select block edges of 4, 8, 16 and 32, which gives log2 sizes of 2 to 5.
- R4: The value 171 << (qbits − 9) is added to |coef| × factor before the right shift by qbits.
- R5: For a negative coefficient the level is the negation of the quantized magnitude. A zero coefficient always gives level 0.
- R6: The level saturates to the 16-bit signed range: a positive result is capped at 32767 and a negative result at −32768.
- R7: A qp value from 52 to 63 is treated as 51.
- R8: While `rst_n` is low, `out_valid` is 0 and `level` is 0.
- R9: `level` is 0 in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient, qp and size code are valid this cycle |
| coef | input | COEF_W (20) | Signed transform coefficient |
| qp | input | 6 | Quantization parameter, 0 to 51 (higher values are clamped) |
| size_code | input | 2 | Transform size code: log2 of the block edge minus 2 |
| out_valid | output | 1 | Level is valid this cycle |
| level | output | 16 | Signed quantized level |

## Verification
Saturation and sign restoration can act on the same result. This happens when a large negative coefficient meets the smallest shift. The bench provokes it with the most negative 20-bit coefficient at qp 0 and size code 3, and judges the result against −32768, while the mirrored positive case must give 32767. A second pairing is tested by streaming vectors on consecutive cycles with changing qp and size. Each result is compared with a value the bench computes for its own vector. This shows that both stages hold their own qp, shift and sign while the next coefficient is already in flight.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
    localparam int QP_W    = 6;
    localparam int QP_MAX  = 51;
    localparam int SIZE_W  = 2;
    localparam int MF_W    = 15;
    localparam int QB_W    = 5;
    localparam int DIV_W   = 4;
    localparam int MOD_W   = 3;
    // 14 + (15 - 8 - 2): shift base at the smallest block size
    localparam int QB_BASE = 19;
    localparam int RND_NUM = 171;
    localparam int RND_SH  = 9;

    typedef logic [MOD_W-1:0] mod6_t;
    typedef logic [DIV_W-1:0] div6_t;
    typedef logic [MF_W-1:0]  mf_t;
    typedef logic [QB_W-1:0]  qbits_t;

    function automatic mf_t mf_lookup(input mod6_t r);
        mf_t m;
        unique case (r)
            3'd0:    m = 15'd26214;
            3'd1:    m = 15'd23302;
            3'd2:    m = 15'd20560;
            3'd3:    m = 15'd16384;
            3'd4:    m = 15'd14564;
            default: m = 15'd13107;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/qnt_qp_split.sv
module qnt_qp_split
    import qnt_pkg::*;
(
    input  logic [QP_W-1:0] qp,
    output div6_t           div6,
    output mod6_t           mod6
);
    localparam int STEPS = QP_MAX / 6;

    logic [QP_W-1:0] qp_c;
    logic [QP_W-1:0] six_div;

    always_comb begin
        qp_c = (qp > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : qp;
        div6 = '0;
        for (int i = 1; i <= STEPS; i++) begin
            if (qp_c >= QP_W'(6 * i))
                div6 = DIV_W'(i);
        end
        six_div = QP_W'({div6, 2'b00}) + QP_W'({div6, 1'b0});
        mod6    = MOD_W'(qp_c - six_div);
    end

    always_comb begin
        // R2
        mod_range_chk: assert (mod6 < 3'd6);
        // R7
        div_range_chk: assert (div6 <= div6_t'(STEPS));
    end
endmodule

// File: rtl/qnt_scale.sv
module qnt_scale
    import qnt_pkg::*;
#(
    parameter int COEF_W = 20,
    localparam int PROD_W = COEF_W + MF_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [COEF_W-1:0] coef,
    input  logic [QP_W-1:0]        qp,
    input  logic [SIZE_W-1:0]      size_code,
    output logic                   s1_valid,
    output logic [PROD_W-1:0]      s1_prod,
    output qbits_t                 s1_qbits,
    output logic                   s1_neg
);
    div6_t              div6;
    mod6_t              mod6;
    logic [COEF_W-1:0]  mag;
    mf_t                mf;
    qbits_t             qbits_d;

    qnt_qp_split u_split (
        .qp   (qp),
        .div6 (div6),
        .mod6 (mod6)
    );

    always_comb begin
        mag     = coef[COEF_W-1] ? COEF_W'(-coef) : COEF_W'(coef);
        mf      = mf_lookup(mod6);
        qbits_d = QB_W'(QB_BASE) + QB_W'(div6) - QB_W'(size_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_prod  <= '0;
            s1_qbits <= QB_W'(QB_BASE);
            s1_neg   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_prod  <= in_valid ? PROD_W'(mag) * PROD_W'(mf) : '0;
            s1_qbits <= qbits_d;
            s1_neg   <= in_valid & coef[COEF_W-1];
        end
    end

    // R3
    qbits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_qbits >= 5'd16 && s1_qbits <= 5'd27));
endmodule

// File: rtl/qnt_round.sv
module qnt_round
    import qnt_pkg::*;
#(
    parameter int COEF_W = 20,
    parameter int OUT_W  = 16,
    localparam int PROD_W = COEF_W + MF_W,
    localparam int SUM_W  = PROD_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic [PROD_W-1:0]       s1_prod,
    input  qbits_t                  s1_qbits,
    input  logic                    s1_neg,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] level
);
    localparam logic [SUM_W-1:0] POS_LIM = SUM_W'((64'd1 << (OUT_W - 1)) - 64'd1);
    localparam logic [SUM_W-1:0] NEG_LIM = SUM_W'(64'd1 << (OUT_W - 1));

    logic [SUM_W-1:0] rnd;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] shifted;
    logic [OUT_W:0]   mag_c;
    logic [OUT_W:0]   signed_w;

    always_comb begin
        rnd     = SUM_W'(RND_NUM) << (s1_qbits - QB_W'(RND_SH));
        sum     = SUM_W'(s1_prod) + rnd;
        shifted = sum >> s1_qbits;
        if (s1_neg)
            mag_c = (shifted > NEG_LIM) ? (OUT_W+1)'(NEG_LIM) : (OUT_W+1)'(shifted);
        else
            mag_c = (shifted > POS_LIM) ? (OUT_W+1)'(POS_LIM) : (OUT_W+1)'(shifted);
        signed_w = s1_neg ? (~mag_c + 1'b1) : mag_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            level     <= '0;
        end else begin
            out_valid <= s1_valid;
            level     <= s1_valid ? signed_w[OUT_W-1:0] : '0;
        end
    end

    // R5
    sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_neg) |=> !level[OUT_W-1]);
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
    import qnt_pkg::*;
#(
    parameter int COEF_W = 20,
    parameter int OUT_W  = 16,
    localparam int PROD_W = COEF_W + MF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COEF_W-1:0] coef,
    input  logic [QP_W-1:0]          qp,
    input  logic [SIZE_W-1:0]        size_code,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  level
);
    logic              s1_valid;
    logic [PROD_W-1:0] s1_prod;
    qbits_t            s1_qbits;
    logic              s1_neg;

    qnt_scale #(.COEF_W(COEF_W)) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .coef      (coef),
        .qp        (qp),
        .size_code (size_code),
        .s1_valid  (s1_valid),
        .s1_prod   (s1_prod),
        .s1_qbits  (s1_qbits),
        .s1_neg    (s1_neg)
    );

    qnt_round #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_round (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_prod   (s1_prod),
        .s1_qbits  (s1_qbits),
        .s1_neg    (s1_neg),
        .out_valid (out_valid),
        .level     (level)
    );

    // R1
    latency_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    // R1
    latency_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (level == '0));
    // R5
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef == '0) |-> ##2 (level == '0));
    // R5
    neg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && level[OUT_W-1]) |-> $past(coef[COEF_W-1], 2));
endmodule

// File: tb/tb_coef_quantizer.sv
module tb_coef_quantizer;
    localparam int COEF_W = 20;
    localparam int OUT_W  = 16;
    localparam int N      = 18;

    localparam int VC [N] = '{100, 100, 100, 100, 100, 100, 1000, -1000, 0, 524287,
                              -524288, 30000, -7777, 5, 123456, -123456, 2047, 9999};
    localparam int VQ [N] = '{0, 1, 2, 3, 4, 5, 22, 22, 30, 0,
                              0, 51, 60, 0, 13, 40, 63, 36};
    localparam int VS [N] = '{0, 0, 0, 0, 0, 0, 1, 2, 3, 3,
                              3, 2, 1, 3, 0, 1, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [COEF_W-1:0] coef = '0;
    logic [5:0] qp = '0;
    logic [1:0] size_code = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] level;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coef_quantizer #(.COEF_W(COEF_W), .OUT_W(OUT_W)) dut (
        .clk, .rst_n, .in_valid, .coef, .qp, .size_code, .out_valid, .level
    );

    function automatic int expect_level(input int c, input int q_in, input int s);
        longint mag, mf, rnd, v;
        int q, qb;
        q   = (q_in > 51) ? 51 : q_in;
        mag = (c < 0) ? -longint'(c) : longint'(c);
        case (q % 6)
            0: mf = 26214;
            1: mf = 23302;
            2: mf = 20560;
            3: mf = 16384;
            4: mf = 14564;
            default: mf = 13107;
        endcase
        qb  = 14 + q / 6 + (15 - 8 - (s + 2));
        rnd = longint'(171) << (qb - 9);
        v   = (mag * mf + rnd) >>> qb;
        if (c < 0) begin
            if (v > 32768) v = 32768;
            return -int'(v);
        end
        if (v > 32767) v = 32767;
        return int'(v);
    endfunction

    function automatic string tag_of(input int i);
        if (VQ[i] > 51) return "R7";
        if (VC[i] == 524287 || VC[i] == -524288) return "R6";
        if (VC[i] < 0 || VC[i] == 0) return "R5";
        if (i < 6) return "R2";
        return "R3 R4";
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic drive(input bit v, input int c, input int q, input int s);
        in_valid  = v;
        coef      = COEF_W'(c);
        qp        = 6'(q);
        size_code = 2'(s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset holds outputs at zero even with valid input
        drive(1'b1, 500, 0, 0);
        repeat (3) @(negedge clk);
        check("R8 out_valid", int'(out_valid), 0);
        check("R8 level", int'(level), 0);
        drive(1'b0, 0, 0, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9
        check("R9 idle level", int'(level), 0);

        // streamed table walk, one vector per cycle (R1 R2 R3 R4 R5 R6 R7)
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R1 out_valid", int'(out_valid), 1);
                check(tag_of(i - 2), int'(level), expect_level(VC[i-2], VQ[i-2], VS[i-2]));
            end
            if (i < N) drive(1'b1, VC[i], VQ[i], VS[i]);
            else       drive(1'b0, 0, 0, 0);
        end
        @(negedge clk);
        check("R1 drained", int'(out_valid), 0);
        check("R9 drained level", int'(level), 0);

        // R1: bubble pattern valid, idle, valid
        drive(1'b1, 777, 12, 1);
        @(negedge clk);
        drive(1'b0, 999, 12, 1);
        @(negedge clk);
        check("R1 bubble first", int'(out_valid), 1);
        check("R2 bubble level", int'(level), expect_level(777, 12, 1));
        drive(1'b1, -777, 12, 1);
        @(negedge clk);
        check("R1 bubble gap", int'(out_valid), 0);
        check("R9 bubble gap level", int'(level), 0);
        drive(1'b0, 0, 0, 0);
        @(negedge clk);
        check("R1 bubble second", int'(out_valid), 1);
        check("R5 bubble level", int'(level), expect_level(-777, 12, 1));

        // R6: saturation and sign in the same result, both directions
        drive(1'b1, -524288, 0, 3);
        @(negedge clk);
        drive(1'b1, 524287, 0, 3);
        @(negedge clk);
        drive(1'b0, 0, 0, 0);
        check("R6 negative clamp", int'(level), -32768);
        @(negedge clk);
        check("R6 positive clamp", int'(level), 32767);

        // R4: rounding term is exactly 171/512 of one step at qbits 16
        drive(1'b1, 5, 0, 3);
        @(negedge clk);
        drive(1'b0, 0, 0, 0);
        @(negedge clk);
        check("R4 round up", int'(level), 2);

        // R7: qp 63 equals qp 51
        drive(1'b1, 400000, 63, 0);
        @(negedge clk);
        drive(1'b1, 400000, 51, 0);
        @(negedge clk);
        drive(1'b0, 0, 0, 0);
        check("R7 qp63", int'(level), expect_level(400000, 51, 0));
        @(negedge clk);
        check("R7 qp51", int'(level), expect_level(400000, 51, 0));

        // R8: reset in mid-stream flushes the pipeline
        drive(1'b1, 4000, 6, 2);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 0, 0, 0);
        @(negedge clk);
        check("R8 mid reset valid", int'(out_valid), 0);
        check("R8 mid reset level", int'(level), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 after reset", int'(out_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule